// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block buffers 9-bit words between a producer clock and a consumer clock that may be unrelated or the same net. Write and read pointers are one bit wider than the storage address. Each pointer crosses into the other clock domain as Gray code through a two-stage synchronizer. The storage is an inferred RAM whose depth is a power of two set by a parameter. The default depth is 64.

The read timing is fixed at master reset. In standard timing, a word reaches the output only after a read request. Status is then reported as "empty" and "full". In fall-through timing, the oldest word moves to the output on its own. Status is then reported as "output ready" and "input ready". The block also drives a half-full flag and two threshold flags, one for near-empty and one for near-full. The thresholds start from one of two built-in defaults and can be reprogrammed.

A partial reset discards all data and keeps the programmed thresholds and the timing mode. A master reset restores everything. A retransmit request rewinds reading to the first word written since the last reset.

Top module: `dual_clk_fifo`

## Requirements
- R1: Every word accepted on the write side is delivered on the read side exactly once, in write order, when the two clocks run at unrelated rates.
- R2: In standard timing (`fwft_sel`=0 during master reset), `empty_or`=1 means no word is stored. A word appears on `rd_data` at the read-clock edge that samples `rd_en`=1 while `empty_or`=0. Just after master reset, `rd_data` is 0.
- R3: In standard timing, `full_ir`=1 means DEPTH words are stored. A write attempted while `full_ir`=1 stores nothing.
- R4: A read request is ignored while no word is available: while `empty_or`=1 in standard timing, or while `empty_or`=0 in fall-through timing. Such a request leaves `rd_data` and the pending data unchanged.
- R5: In fall-through timing (`fwft_sel`=1 during master reset), `empty_or` means "output ready". The oldest word is shown on `rd_data` with no request, and `rd_en`=1 with `empty_or`=1 consumes it. `full_ir` means "input ready". It drops once DEPTH words are in storage, so DEPTH+1 words are held in total, counting the one on the output.
- R6: The timing mode is captured from `fwft_sel` only while `mrst` is high. Changing `fwft_sel` afterwards has no effect.
- R7: `half_full`=1 exactly when the write-side occupancy exceeds DEPTH/2.
- R8: Occupancy counts the words in storage; in fall-through timing, the word on the output is not counted. `almost_empty`=1 when the read-side occupancy is at most the near-empty threshold. `almost_full`=1 when the write-side occupancy is at least DEPTH minus the near-full threshold.
- R9: Master reset sets both thresholds to OFS_DEF0 (8) when `ofs_sel`=0, and to OFS_DEF1 (16) when `ofs_sel`=1.
- R10: `ofs_ld`=1 on a write-clock edge loads `ae_ofs_in` and `af_ofs_in` as the thresholds. A partial reset empties the FIFO and keeps these thresholds. A later master reset restores the default.
- R11: `out_en`=0 forces `rd_data` to 0 without disturbing the held word or the status flags.
- R12: A one-cycle `rt` pulse rewinds reading to the first word written since the last reset, so that the same words are read again in the same order. This holds when at most DEPTH words have been written since that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous in each domain, active high |
| prst | input | 1 | Partial reset, synchronous in each domain, active high |
| fwft_sel | input | 1 | Timing mode captured at master reset (1 = fall-through) |
| ofs_sel | input | 1 | Chooses which default threshold pair master reset loads |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Word to write |
| ofs_ld | input | 1 | Load the programmed thresholds (write clock) |
| ae_ofs_in | input | AW+1 | Near-empty threshold to load |
| af_ofs_in | input | AW+1 | Near-full threshold to load |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Retransmit (read clock) |
| out_en | input | 1 | Output gate; 0 forces `rd_data` to zero |
| rd_data | output | 9 | Read word |
| empty_or | output | 1 | Empty (standard) or output ready (fall-through) |
| full_ir | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | Occupancy above DEPTH/2 |
| almost_empty | output | 1 | Occupancy at or below the near-empty threshold |
| almost_full | output | 1 | Occupancy at or above DEPTH minus the near-full threshold |

## Verification
The data path is exercised in both timings with two kinds of traffic. The first kind writes a burst and then drains it. This separates ordering errors from pointer-crossing errors. The second kind runs writer and reader at the same time on unrelated clock periods, with irregular gaps, which exposes stale or mis-converted Gray pointers.

Filling past capacity shows whether a write is lost or duplicated at the boundary. Reading past empty shows the same for reads. The capacity reached tells the two timings apart: DEPTH words in standard timing and DEPTH+1 in fall-through timing.

The occupancy is stepped one word at a time across each flag threshold, first with both default pairs and then with programmed values. This separates an off-by-one compare from a wrong threshold source. Repeating the step after a partial reset and after a master reset shows which reset keeps the thresholds.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Width of one stored word
    localparam int WORD_W = 9;

    // Read timing captured at master reset
    typedef enum logic {
        TM_STD  = 1'b0,
        TM_FWFT = 1'b1
    } tmode_e;

    // Read-side output stage: held word plus presence bit
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } out_stage_t;

endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int AW = 6,
    parameter int DW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl import dcf_pkg::*; #(
    parameter int AW       = 6,
    parameter int OFS_DEF0 = 8,
    parameter int OFS_DEF1 = 16
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          wr_en,
    input  logic          mode_in,
    input  logic          ofs_sel,
    input  logic          ofs_ld,
    input  logic [AW:0]   ae_in,
    input  logic [AW:0]   af_in,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW:0]   wptr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          half,
    output logic          afull,
    output tmode_e        mode,
    output logic [AW:0]   ae_ofs
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_V = PW'(2 ** AW);
    localparam logic [PW-1:0] HALF_V  = PW'(2 ** (AW - 1));

    logic [PW-1:0] af_ofs, rbin, cnt, wnext;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_s >> i);
        cnt   = wptr - rbin;
        full  = (cnt == DEPTH_V);
        half  = (cnt > HALF_V);
        afull = (cnt >= (DEPTH_V - af_ofs));
        we    = wr_en && !full && !mrst && !prst;
        wnext = wptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (we) begin
            wptr  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end

    // Settings: master reset restores, partial reset keeps
    always_ff @(posedge clk) begin
        if (mrst) begin
            mode   <= tmode_e'(mode_in);
            ae_ofs <= ofs_sel ? PW'(OFS_DEF1) : PW'(OFS_DEF0);
            af_ofs <= ofs_sel ? PW'(OFS_DEF1) : PW'(OFS_DEF0);
        end else if (ofs_ld && !prst) begin
            ae_ofs <= ae_in;
            af_ofs <= af_in;
        end
    end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl import dcf_pkg::*; #(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              rt,
    input  logic              rd_en,
    input  logic              mode_in,
    input  logic [AW:0]       wgray_s,
    input  logic [AW:0]       ae_ofs,
    input  logic [WORD_W-1:0] mem_q,
    output logic [AW:0]       rptr,
    output logic [AW:0]       rgray,
    output logic              sempty,
    output logic              aempty,
    output logic              stat,
    output out_stage_t        ostg,
    output tmode_e            mode
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wbin, cnt, rnext;
    logic          take;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_s >> i);
        cnt    = wbin - rptr;
        sempty = (cnt == '0);
        aempty = (cnt <= ae_ofs);
        rnext  = rptr + 1'b1;
        if (mode == TM_FWFT) take = !sempty && (!ostg.valid || rd_en);
        else                 take = !sempty && rd_en;
        stat   = (mode == TM_FWFT) ? ostg.valid : sempty;
    end

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            rptr <= '0;
            rgray <= '0;
            ostg <= '0;
        end else if (rt) begin
            rptr <= '0;
            rgray <= '0;
            ostg.valid <= 1'b0;
        end else if (take) begin
            rptr <= rnext;
            rgray <= rnext ^ (rnext >> 1);
            ostg.word <= mem_q;
            ostg.valid <= 1'b1;
        end else if (mode == TM_FWFT && rd_en) begin
            ostg.valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (mrst) mode <= tmode_e'(mode_in);
    end
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo import dcf_pkg::*; #(
    parameter int AW       = 6,
    parameter int OFS_DEF0 = 8,
    parameter int OFS_DEF1 = 16
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              fwft_sel,
    input  logic              ofs_sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ofs_ld,
    input  logic [AW:0]       ae_ofs_in,
    input  logic [AW:0]       af_ofs_in,
    input  logic              rd_en,
    input  logic              rt,
    input  logic              out_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty_or,
    output logic              full_ir,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int PW = AW + 1;

    logic          w_we, w_full;
    logic [PW-1:0] w_ptr, w_gray, w_gray_s, r_ptr, r_gray, r_gray_s, ae_ofs;
    logic          r_sempty;
    tmode_e        w_mode, r_mode;
    out_stage_t    r_ostg;
    logic [WORD_W-1:0] mem_q;

    dcf_wr_ctl #(.AW(AW), .OFS_DEF0(OFS_DEF0), .OFS_DEF1(OFS_DEF1)) u_wr (
        .clk(wr_clk), .mrst(mrst), .prst(prst), .wr_en(wr_en),
        .mode_in(fwft_sel), .ofs_sel(ofs_sel), .ofs_ld(ofs_ld),
        .ae_in(ae_ofs_in), .af_in(af_ofs_in), .rgray_s(r_gray_s),
        .we(w_we), .wptr(w_ptr), .wgray(w_gray), .full(w_full),
        .half(half_full), .afull(almost_full), .mode(w_mode), .ae_ofs(ae_ofs)
    );

    dcf_sync2 #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst(mrst || prst), .d(r_gray), .q(r_gray_s)
    );

    dcf_sync2 #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst(mrst || prst), .d(w_gray), .q(w_gray_s)
    );

    dcf_ram #(.AW(AW), .DW(WORD_W)) u_ram (
        .wclk(wr_clk), .we(w_we), .waddr(w_ptr[AW-1:0]), .wdata(wr_data),
        .raddr(r_ptr[AW-1:0]), .rdata(mem_q)
    );

    dcf_rd_ctl #(.AW(AW)) u_rd (
        .clk(rd_clk), .mrst(mrst), .prst(prst), .rt(rt), .rd_en(rd_en),
        .mode_in(fwft_sel), .wgray_s(w_gray_s), .ae_ofs(ae_ofs), .mem_q(mem_q),
        .rptr(r_ptr), .rgray(r_gray), .sempty(r_sempty), .aempty(almost_empty),
        .stat(empty_or), .ostg(r_ostg), .mode(r_mode)
    );

    assign full_ir = (w_mode == TM_FWFT) ? !w_full : w_full;
    assign rd_data = out_en ? r_ostg.word : '0;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int PW = 7,
    parameter int DW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          mrst,
    input logic          prst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          rt,
    input logic          w_full,
    input logic          half_full,
    input logic [PW-1:0] w_ptr,
    input logic [PW-1:0] r_ptr,
    input logic          r_sempty,
    input logic          r_fwft,
    input logic          r_valid,
    input logic [DW-1:0] r_word
);
    // R3: write while full leaves the write pointer in place
    a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        (w_full && wr_en) |=> $stable(w_ptr));

    // R1: without a write request the write pointer does not move
    a_r1_wptr_idle: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        !wr_en |=> $stable(w_ptr));

    // R4: standard timing, read with nothing stored leaves pointer and word
    a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        (!r_fwft && r_sempty && !rt) |=> ($stable(r_ptr) && $stable(r_word)));

    // R5: a shown fall-through word stays until it is consumed
    a_r5_or_holds: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        (r_fwft && r_valid && !rd_en && !rt) |=> (r_valid && $stable(r_word)));

    // R7: a full FIFO is necessarily above half
    a_r7_full_half: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        w_full |-> half_full);
endmodule

bind dual_clk_fifo dcf_checker #(.PW(AW + 1), .DW(dcf_pkg::WORD_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
    .wr_en(wr_en), .rd_en(rd_en), .rt(rt), .w_full(w_full),
    .half_full(half_full), .w_ptr(w_ptr), .r_ptr(r_ptr),
    .r_sempty(r_sempty), .r_fwft(r_mode == dcf_pkg::TM_FWFT),
    .r_valid(r_ostg.valid), .r_word(r_ostg.word)
);

// File: tb/dual_clk_fifo_tb.sv
module dual_clk_fifo_tb;
    localparam int WCLK_P = 10;
    localparam int RCLK_P = 14;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic wr_clk = 0, rd_clk = 0;
    logic mrst = 1, prst = 0, fwft_sel = 0, ofs_sel = 0;
    logic wr_en = 0, ofs_ld = 0, rd_en = 0, rt = 0, out_en = 1;
    logic [8:0] wr_data = '0;
    logic [AW:0] ae_ofs_in = '0, af_ofs_in = '0;
    logic [8:0] rd_data;
    logic empty_or, full_ir, half_full, almost_empty, almost_full;

    int vecs = 0, fails = 0;
    bit cur_fwft = 0;
    bit done = 0;
    logic [8:0] q[$];

    always #(WCLK_P/2) wr_clk = ~wr_clk;
    always #(RCLK_P/2) rd_clk = ~rd_clk;

    dual_clk_fifo #(.AW(AW)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
        .fwft_sel(fwft_sel), .ofs_sel(ofs_sel), .wr_en(wr_en), .wr_data(wr_data),
        .ofs_ld(ofs_ld), .ae_ofs_in(ae_ofs_in), .af_ofs_in(af_ofs_in),
        .rd_en(rd_en), .rt(rt), .out_en(out_en), .rd_data(rd_data),
        .empty_or(empty_or), .full_ir(full_ir), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(string req, int act, int exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit wfull();
        return cur_fwft ? !full_ir : full_ir;
    endfunction

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic do_reset(bit master, bit fwft, bit osel);
        @(negedge rd_clk);
        wr_en = 0; rd_en = 0; rt = 0; ofs_ld = 0;
        fwft_sel = fwft; ofs_sel = osel;
        if (master) begin mrst = 1; cur_fwft = fwft; end
        else prst = 1;
        repeat (6) @(negedge rd_clk);
        mrst = 0; prst = 0;
        q.delete();
        repeat (6) @(negedge rd_clk);
    endtask

    // Attempt n writes; the model keeps only those made while not full
    task automatic write_n(int n, int base);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_data = 9'(base + i);
            wr_en = 1;
            if (!wfull()) q.push_back(wr_data);
        end
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic read_std_all(string req);
        int guard = 0;
        while (q.size() > 0 && guard < 4000) begin
            @(negedge rd_clk);
            guard++;
            if (empty_or == 0) begin
                rd_en = 1;
                @(negedge rd_clk);
                rd_en = 0;
                chk(req, rd_data, q.pop_front());
            end
        end
        chk({req, " drained"}, q.size(), 0);
    endtask

    task automatic read_fwft_all(string req);
        int guard = 0;
        while (q.size() > 0 && guard < 4000) begin
            @(negedge rd_clk);
            guard++;
            if (empty_or == 1 && ($urandom % 4 != 0)) begin
                chk(req, rd_data, q[0]);
                void'(q.pop_front());
                rd_en = 1;
            end else rd_en = 0;
        end
        @(negedge rd_clk);
        rd_en = 0;
        chk({req, " drained"}, q.size(), 0);
    endtask

    // Concurrent writer and reader at unrelated rates
    task automatic stress(int n, string req);
        int got = 0;
        fork
            begin
                for (int i = 0; i < n; ) begin
                    @(negedge wr_clk);
                    if ($urandom % 3 == 0) wr_en = 0;
                    else begin
                        wr_data = 9'(i * 7 + 3);
                        wr_en = 1;
                        if (!wfull()) begin q.push_back(wr_data); i++; end
                    end
                end
                @(negedge wr_clk);
                wr_en = 0;
            end
            begin
                bit pend = 0;
                int guard = 0;
                while (got < n && guard < 20000) begin
                    @(negedge rd_clk);
                    guard++;
                    if (!cur_fwft) begin
                        if (pend) begin chk(req, rd_data, q.pop_front()); got++; end
                        pend = (empty_or == 0) && ($urandom % 3 != 0);
                        rd_en = pend;
                    end else begin
                        if (empty_or == 1 && ($urandom % 3 != 0)) begin
                            chk(req, rd_data, q.pop_front());
                            got++;
                            rd_en = 1;
                        end else rd_en = 0;
                    end
                end
                @(negedge rd_clk);
                rd_en = 0;
                chk({req, " count"}, got, n);
            end
        join
    endtask

    task automatic t_reset_state();
        do_reset(1, 0, 0);
        chk("R2 empty after reset", empty_or, 1);
        chk("R3 not full after reset", full_ir, 0);
        chk("R7 half after reset", half_full, 0);
        chk("R8 afull after reset", almost_full, 0);
        chk("R8 aempty after reset", almost_empty, 1);
        chk("R2 data after reset", rd_data, 0);
    endtask

    task automatic t_std_burst();
        do_reset(1, 0, 0);
        write_n(40, 9'h040);
        settle();
        chk("R2 not empty with data", empty_or, 0);
        read_std_all("R1 R2 burst");
        stress(300, "R1 std stress");
    endtask

    task automatic t_flags_fill();
        logic [8:0] last;
        do_reset(1, 0, 0);
        write_n(8, 0);  settle();
        chk("R9 aempty at 8 (def0)", almost_empty, 1);
        write_n(1, 8);  settle();
        chk("R8 aempty at 9", almost_empty, 0);
        write_n(23, 9); settle();
        chk("R7 half at 32", half_full, 0);
        write_n(1, 32); settle();
        chk("R7 half at 33", half_full, 1);
        write_n(22, 33); settle();
        chk("R8 afull at 55", almost_full, 0);
        write_n(1, 55); settle();
        chk("R8 afull at 56", almost_full, 1);
        write_n(11, 56); settle();
        chk("R3 full flag", full_ir, 1);
        chk("R3 stored count", q.size(), DEPTH);
        last = q[$];
        read_std_all("R3 no extra word");
        // R4: reads on empty are ignored
        @(negedge rd_clk); rd_en = 1;
        repeat (3) @(negedge rd_clk);
        rd_en = 0;
        chk("R4 data kept on empty read", rd_data, last);
        chk("R4 still empty", empty_or, 1);
        write_n(2, 9'h1F0); settle();
        read_std_all("R4 order after empty reads");

        do_reset(1, 0, 1);
        write_n(16, 0); settle();
        chk("R9 aempty at 16 (def1)", almost_empty, 1);
        write_n(1, 16); settle();
        chk("R9 aempty at 17 (def1)", almost_empty, 0);
        write_n(30, 17); settle();
        chk("R9 afull at 47 (def1)", almost_full, 0);
        write_n(1, 47); settle();
        chk("R9 afull at 48 (def1)", almost_full, 1);
    endtask

    task automatic t_prog_prst();
        do_reset(1, 0, 0);
        @(negedge wr_clk);
        ofs_ld = 1; ae_ofs_in = 3; af_ofs_in = 4;
        @(negedge wr_clk);
        ofs_ld = 0;
        write_n(3, 0); settle();
        chk("R10 prog aempty at 3", almost_empty, 1);
        write_n(1, 3); settle();
        chk("R10 prog aempty at 4", almost_empty, 0);
        do_reset(0, 1, 1);
        chk("R10 empty after partial", empty_or, 1);
        write_n(3, 0); settle();
        chk("R10 kept aempty at 3", almost_empty, 1);
        chk("R6 mode kept by partial", empty_or, 0);
        write_n(1, 3); settle();
        chk("R10 kept aempty at 4", almost_empty, 0);
        write_n(56, 4); settle();
        chk("R10 kept afull at 60", almost_full, 1);
        do_reset(1, 0, 0);
        write_n(4, 0); settle();
        chk("R10 default after master", almost_empty, 1);
    endtask

    task automatic t_fwft();
        do_reset(1, 1, 0);
        fwft_sel = 0;  // R6: late change must be ignored
        chk("R5 not ready after reset", empty_or, 0);
        chk("R5 input ready after reset", full_ir, 1);
        write_n(1, 9'h1A5); settle();
        chk("R5 R6 fall-through ready", empty_or, 1);
        chk("R5 R6 fall-through word", rd_data, 9'h1A5);
        @(negedge rd_clk); out_en = 0;
        @(negedge rd_clk);
        chk("R11 gated output", rd_data, 0);
        out_en = 1;
        @(negedge rd_clk);
        chk("R11 word restored", rd_data, 9'h1A5);
        chk("R11 ready unchanged", empty_or, 1);
        read_fwft_all("R5 single");
        @(negedge rd_clk); rd_en = 1;
        repeat (3) @(negedge rd_clk);
        rd_en = 0;
        write_n(2, 9'h0C0); settle();
        read_fwft_all("R4 fwft after idle reads");
        write_n(DEPTH + 6, 0); settle();
        chk("R5 input ready low", full_ir, 0);
        chk("R5 capacity", q.size(), DEPTH + 1);
        read_fwft_all("R5 R1 fwft burst");
        stress(300, "R1 fwft stress");
    endtask

    task automatic t_retransmit();
        logic [8:0] copy[$];
        do_reset(1, 0, 0);
        write_n(5, 9'h100); settle();
        copy = q;
        read_std_all("R12 first pass");
        @(negedge rd_clk); rt = 1;
        @(negedge rd_clk); rt = 0;
        settle();
        q = copy;
        read_std_all("R12 second pass");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        end
    endtask

    initial begin
        #(WCLK_P * 150000);
        fails++;
        $display("FAIL R1 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        t_reset_state();
        t_std_burst();
        t_flags_fill();
        t_prog_prst();
        t_fwft();
        t_retransmit();
        summary();
        $finish;
    end
endmodule